// File: doc/BRIEF.md
# Square-Law AM Envelope Detector

The block recovers the envelope of an amplitude-modulated signal from a stream of 12-bit offset-binary converter codes. Each accepted sample is re-centred on its zero code (0x80B, not mid-scale) into signed form. The sample then runs through a 25-tap band-select FIR filter. The filtered value is squared and smoothed by a 25-tap lowpass FIR filter. Any negative smoothing result is clamped to zero, and a bit-serial integer square root returns the envelope magnitude.

The root is shifted right by a per-sample scaling amount and added back onto the zero code. The result saturates at a ceiling code of 0xCCF, so that it can drive a DAC directly. Both ends use valid/ready handshakes. The input stalls with ready low while a sample is in flight, so exactly one output code leaves for every sample accepted, in order. Filter coefficients are elaboration-time parameters.

Top module: `am_env_det`

## Requirements
- R1: An input code of 0x80B is treated as signed zero. A stream made only of 0x80B codes produces output codes of exactly 0x80B.
- R2: Each output is computed in this order: band FIR on the re-centred sample, square, lowpass FIR on the squares, clamp at zero, floor square root, scaling.
- R3: Each FIR computes the sum over taps k = 0..24 of coef[k] times the input accepted k samples earlier, where k = 0 is the newest. Tap history is zero after reset.
- R4: If the lowpass sum is negative, the root is zero and the output code is 0x80B.
- R5: The root r of a non-negative value v satisfies r*r <= v < (r+1)*(r+1).
- R6: The output code is min(0x80B + (r >> s), 0xCCF). Here s is the value of scale_sh_i captured in the cycle the sample is accepted.
- R7: After a sample is accepted, in_ready_o stays low until its result is consumed. Samples offered during that time are not taken, and every accepted sample yields exactly one output, in order.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o stays unchanged.
- R9: In the cycle an output is consumed, a new input sample can be accepted.
- R10: An asynchronous reset clears both filter histories, so no earlier sample affects later outputs.
- R11: Intermediate widths hold full-scale input with the largest coefficient sums without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample offered |
| in_ready_o | output | 1 | Input sample can be taken |
| in_data_i | input | 12 | Offset-binary input code |
| scale_sh_i | input | 5 | Right-shift applied to the root, captured with the sample |
| out_valid_o | output | 1 | Output code available |
| out_ready_i | input | 1 | Consumer takes the output code |
| out_data_o | output | 12 | Offset-binary envelope code |

## Verification
The consumption of a finished output and the acceptance of the next input can land on the same clock edge. This happens because ready is offered again as soon as the consumer is ready. The bench provokes it by presenting a new sample at the moment the previous result appears, with out_ready_i held high. It then requires that the old code was valid and correct in that cycle, that the new sample was taken (valid drops the next cycle), and that the new result matches its own model value. A companion case holds out_ready_i low and offers a foreign sample. That sample must be refused, and it must leave no trace in the following results.

// File: rtl/am_env_pkg.sv
package am_env_pkg;
  localparam int          CODE_W    = 12;
  localparam logic [11:0] ZERO_CODE = 12'h80B;
  localparam logic [11:0] CEIL_CODE = 12'hCCF;
  localparam int          TAPS_DEF  = 25;
  localparam int          COEF_DEF  = 8;

  // tap 24 first, tap 0 (newest sample) last
  localparam logic [TAPS_DEF*COEF_DEF-1:0] BAND_COEFS = {
    8'sd1, 8'sd0, -8'sd3, 8'sd0, 8'sd6, 8'sd0, -8'sd10, 8'sd0, 8'sd14, 8'sd0,
    -8'sd17, 8'sd0, 8'sd18, 8'sd0, -8'sd17, 8'sd0, 8'sd14, 8'sd0, -8'sd10,
    8'sd0, 8'sd6, 8'sd0, -8'sd3, 8'sd0, 8'sd1};

  localparam logic [TAPS_DEF*COEF_DEF-1:0] SMOOTH_COEFS = {
    8'sd1, 8'sd1, 8'sd2, 8'sd3, 8'sd4, 8'sd5, 8'sd6, 8'sd7, 8'sd8, 8'sd8,
    8'sd8, 8'sd8, 8'sd8, 8'sd8, 8'sd8, 8'sd8, 8'sd8, 8'sd7, 8'sd6, 8'sd5,
    8'sd4, 8'sd3, 8'sd2, 8'sd1, -8'sd1};

  typedef enum logic [2:0] {
    ST_IDLE, ST_SQ, ST_LP, ST_ROOT, ST_DONE
  } env_state_e;
endpackage

// File: rtl/am_fir.sv
module am_fir #(
  parameter int IN_W   = 13,
  parameter int COEF_W = 8,
  parameter int TAPS   = 25,
  parameter int ACC_W  = IN_W + COEF_W + $clog2(TAPS),
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_i,
  input  logic signed [IN_W-1:0]  din_i,
  output logic signed [ACC_W-1:0] sum_o
);
  logic signed [IN_W-1:0] hist [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist[g] <= '0;
      else if (shift_i) hist[g] <= (g == 0) ? din_i : hist[(g == 0) ? 0 : g-1];
    end
  end

  always_comb begin
    logic signed [ACC_W-1:0] ce, he;
    sum_o = '0;
    for (int k = 0; k < TAPS; k++) begin
      ce    = ACC_W'($signed(COEFS[k*COEF_W +: COEF_W]));
      he    = ACC_W'(hist[k]);
      sum_o = sum_o + ce * he;
    end
  end

  AST_HIST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i && $past(!shift_i) |-> $stable(sum_o)) else $error("fir moved");  // R3
endmodule

// File: rtl/am_isqrt.sv
module am_isqrt #(
  parameter int ROOT_W = 32,
  localparam int RAD_W = 2 * ROOT_W,
  localparam int REM_W = ROOT_W + 3,
  localparam int CNT_W = $clog2(ROOT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RAD_W-1:0]  rad_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ROOT_W-1:0] root_o
);
  logic [RAD_W-1:0]        d_q;
  logic signed [REM_W-1:0] r_q, r_sh, r_n;
  logic [ROOT_W-1:0]       q_q;
  logic [CNT_W-1:0]        cnt_q;

  // non-restoring step: sign of remainder picks subtract or add
  always_comb begin
    r_sh = {r_q[REM_W-3:0], d_q[RAD_W-1 -: 2]};
    if (!r_q[REM_W-1]) r_n = r_sh - REM_W'({q_q, 2'b01});
    else               r_n = r_sh + REM_W'({q_q, 2'b11});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q    <= '0;
      r_q    <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        d_q    <= rad_i;
        r_q    <= '0;
        q_q    <= '0;
        cnt_q  <= CNT_W'(ROOT_W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        d_q   <= {d_q[RAD_W-3:0], 2'b00};
        r_q   <= r_n;
        q_q   <= {q_q[ROOT_W-2:0], ~r_n[REM_W-1]};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign root_o = q_q;

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o) else $error("root restarted");  // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done stuck");  // R5
endmodule

// File: rtl/am_out_map.sv
module am_out_map #(
  parameter int ROOT_W = 32,
  parameter int SH_W   = 5,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] ZERO = 12'h80B,
  parameter logic [CODE_W-1:0] CEIL = 12'hCCF,
  localparam logic [ROOT_W-1:0] HEAD = ROOT_W'(CEIL - ZERO)
) (
  input  logic [ROOT_W-1:0] root_i,
  input  logic [SH_W-1:0]   sh_i,
  output logic [CODE_W-1:0] code_o
);
  logic [ROOT_W-1:0] shifted;

  always_comb begin
    shifted = root_i >> sh_i;
    if (shifted > HEAD) code_o = CEIL;
    else                code_o = ZERO + shifted[CODE_W-1:0];
  end
endmodule

// File: rtl/am_env_det.sv
module am_env_det
  import am_env_pkg::*;
#(
  parameter int TAPS   = TAPS_DEF,
  parameter int COEF_W = COEF_DEF,
  parameter logic [TAPS*COEF_W-1:0] BP_COEFS = BAND_COEFS,
  parameter logic [TAPS*COEF_W-1:0] LP_COEFS = SMOOTH_COEFS,
  localparam int SMP_W  = CODE_W + 1,
  localparam int BP_W   = SMP_W + COEF_W + $clog2(TAPS),
  localparam int SQ_W   = 2 * BP_W,
  localparam int LP_W   = SQ_W + COEF_W + $clog2(TAPS),
  localparam int ROOT_W = (LP_W - 1) / 2,
  localparam int RAD_W  = 2 * ROOT_W,
  localparam int SH_W   = $clog2(ROOT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CODE_W-1:0] in_data_i,
  input  logic [SH_W-1:0]   scale_sh_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CODE_W-1:0] out_data_o
);
  env_state_e              state_q;
  logic                    in_fire;
  logic signed [SMP_W-1:0] smp;
  logic signed [BP_W-1:0]  bp_sum;
  logic signed [SQ_W-1:0]  sq;
  logic signed [LP_W-1:0]  lp_sum;
  logic [RAD_W-1:0]        rad;
  logic [SH_W-1:0]         sh_q;
  logic                    root_start, root_busy, root_done;
  logic [ROOT_W-1:0]       root;
  logic [CODE_W-1:0]       code, out_q;

  assign in_ready_o = (state_q == ST_IDLE) || (state_q == ST_DONE && out_ready_i);
  assign in_fire    = in_valid_i && in_ready_o;
  assign smp        = SMP_W'(in_data_i) - SMP_W'(ZERO_CODE);

  am_fir #(.IN_W(SMP_W), .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(BP_W), .COEFS(BP_COEFS))
  u_band (.clk_i, .rst_ni, .shift_i(in_fire), .din_i(smp), .sum_o(bp_sum));

  assign sq = SQ_W'(bp_sum) * SQ_W'(bp_sum);

  am_fir #(.IN_W(SQ_W), .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(LP_W), .COEFS(LP_COEFS))
  u_smooth (.clk_i, .rst_ni, .shift_i(state_q == ST_SQ), .din_i(sq), .sum_o(lp_sum));

  assign rad        = lp_sum[LP_W-1] ? '0 : lp_sum[RAD_W-1:0];
  assign root_start = (state_q == ST_LP);

  am_isqrt #(.ROOT_W(ROOT_W)) u_root (
    .clk_i, .rst_ni, .start_i(root_start), .rad_i(rad),
    .busy_o(root_busy), .done_o(root_done), .root_o(root));

  am_out_map #(.ROOT_W(ROOT_W), .SH_W(SH_W), .CODE_W(CODE_W),
               .ZERO(ZERO_CODE), .CEIL(CEIL_CODE))
  u_map (.root_i(root), .sh_i(sh_q), .code_o(code));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      out_q   <= ZERO_CODE;
    end else begin
      if (in_fire) sh_q <= scale_sh_i;
      unique case (state_q)
        ST_IDLE: if (in_fire) state_q <= ST_SQ;
        ST_SQ:   state_q <= ST_LP;
        ST_LP:   state_q <= ST_ROOT;
        ST_ROOT: if (root_done) begin
          out_q   <= code;
          state_q <= ST_DONE;
        end
        ST_DONE: if (out_ready_i) state_q <= in_fire ? ST_SQ : ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid_o = (state_q == ST_DONE);
  assign out_data_o  = out_q;

  // assertion helpers
  logic [RAD_W+1:0] r_lo, r_hi;
  assign r_lo = (RAD_W+2)'(root) * (RAD_W+2)'(root);
  assign r_hi = ((RAD_W+2)'(root) + 1'b1) * ((RAD_W+2)'(root) + 1'b1);

  AST_ROOT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    root_done |-> (r_lo <= (RAD_W+2)'(rad)) && (r_hi > (RAD_W+2)'(rad))) else $error("root");  // R5
  AST_NEG_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    root_done && lp_sum < 0 |-> root == '0) else $error("clamp");  // R4
  AST_BUSY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire |=> !in_ready_o && !out_valid_o) else $error("stall");  // R7
  AST_ONE_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire |-> !out_valid_o || out_ready_i) else $error("overrun");  // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)) else $error("hold");  // R8
  AST_OUT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o >= ZERO_CODE && out_data_o <= CEIL_CODE) else $error("range");  // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SQ |-> !sq[SQ_W-1]) else $error("square wrapped");  // R11
  AST_ROOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    root_busy |-> state_q == ST_ROOT) else $error("root out of step");  // R2
endmodule

// File: tb/am_env_det_tb.sv
module am_env_det_tb;
  import am_env_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [11:0] in_data = ZERO_CODE, out_data;
  logic [4:0]  scale_sh = '0;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  am_env_det u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .scale_sh_i(scale_sh), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data));

  // independent reference model
  int     m_bp [TAPS_DEF];
  longint m_lp [TAPS_DEF];

  function automatic void m_clear();
    for (int k = 0; k < TAPS_DEF; k++) begin m_bp[k] = 0; m_lp[k] = 0; end
  endfunction

  function automatic longint unsigned m_isqrt(longint unsigned v);
    longint unsigned r = 0, t;
    for (int b = 31; b >= 0; b--) begin
      t = r | (64'd1 << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  function automatic logic [11:0] m_step(logic [11:0] code, int sh);
    int bp = 0; longint lp = 0; longint unsigned r;
    for (int k = TAPS_DEF-1; k > 0; k--) m_bp[k] = m_bp[k-1];
    m_bp[0] = int'(code) - int'(ZERO_CODE);
    for (int k = 0; k < TAPS_DEF; k++)
      bp += int'($signed(BAND_COEFS[k*COEF_DEF +: COEF_DEF])) * m_bp[k];
    for (int k = TAPS_DEF-1; k > 0; k--) m_lp[k] = m_lp[k-1];
    m_lp[0] = longint'(bp) * longint'(bp);
    for (int k = 0; k < TAPS_DEF; k++)
      lp += longint'($signed(SMOOTH_COEFS[k*COEF_DEF +: COEF_DEF])) * m_lp[k];
    r = (lp < 0) ? 0 : m_isqrt(longint'(lp));
    r = r >> sh;
    return (r > longint'(CEIL_CODE - ZERO_CODE)) ? CEIL_CODE : ZERO_CODE + 12'(r);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic push(logic [11:0] code, logic [4:0] sh);
    @(negedge clk);
    in_data = code; scale_sh = sh; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pull(logic [11:0] exp, string tag);
    while (!out_valid) @(negedge clk);
    check(out_data == exp, tag, out_data, exp);
    @(negedge clk);
  endtask

  task automatic run_one(logic [11:0] code, logic [4:0] sh, string tag);
    logic [11:0] e = m_step(code, 5'(sh));
    push(code, sh);
    pull(e, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_clear();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(in_ready == 1'b1, "R7 reset ready", in_ready, 1);
    check(out_valid == 1'b0, "R7 reset valid", out_valid, 0);
  endtask

  task automatic t_zero_level();  // R1
    for (int i = 0; i < 30; i++) run_one(ZERO_CODE, 5'd0, "R1 zero level");
  endtask

  task automatic t_clamp();  // R4: newest smoothing tap is negative
    logic [11:0] e;
    do_reset();
    e = m_step(12'hFFF, 0);
    check(e == ZERO_CODE, "R4 model", e, ZERO_CODE);
    push(12'hFFF, 5'd0);
    pull(e, "R4 clamp");
  endtask

  task automatic t_impulse();  // R2 R3 R5
    do_reset();
    run_one(12'hFFF, 5'd6, "R3 impulse");
    for (int i = 0; i < 30; i++) run_one(ZERO_CODE, 5'd6, "R2 impulse tail");
  endtask

  task automatic t_tone();  // R2 R5 R6: modulated alternating pattern
    for (int i = 0; i < 40; i++) begin
      int a = 200 + 40 * (i % 9);
      logic [11:0] c = (i % 2) ? 12'(int'(ZERO_CODE) + a) : 12'(int'(ZERO_CODE) - a);
      run_one(c, 5'(8 + i % 5), "R5 tone");
    end
  endtask

  task automatic t_scale();  // R6: shift 0 saturates, shift 31 returns zero code
    do_reset();
    for (int i = 0; i < 6; i++) run_one((i % 2) ? 12'hC00 : 12'h400, 5'd0, "R6 ceil");
    check(out_data == CEIL_CODE, "R6 ceiling hit", out_data, CEIL_CODE);
    for (int i = 0; i < 4; i++) run_one((i % 2) ? 12'hC00 : 12'h400, 5'd31, "R6 floor");
  endtask

  task automatic t_full_swing();  // R11
    do_reset();
    for (int i = 0; i < 50; i++)
      run_one(((i / 2) % 2) ? 12'hFFF : 12'h000, 5'd14, "R11 full swing");
  endtask

  task automatic t_backpressure();  // R7 R8
    logic [11:0] ea, eb, held;
    ea = m_step(12'hA00, 8);
    out_ready = 1'b0;
    push(12'hA00, 5'd8);
    while (!out_valid) @(negedge clk);
    held = out_data;
    check(held == ea, "R8 first", held, ea);
    in_data = 12'hFFF; scale_sh = 5'd0; in_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid && out_data == held, "R8 hold", out_data, held);
      check(in_ready == 1'b0, "R7 refuse", in_ready, 0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    eb = m_step(12'h600, 8);
    push(12'h600, 5'd8);
    pull(eb, "R7 no trace");
  endtask

  task automatic t_overlap();  // R9
    logic [11:0] ea, eb;
    ea = m_step(12'hB00, 7);
    eb = m_step(12'h500, 7);
    push(12'hB00, 5'd7);
    while (!out_valid) @(negedge clk);
    check(out_data == ea, "R9 old", out_data, ea);
    in_data = 12'h500; scale_sh = 5'd7; in_valid = 1'b1;
    check(in_ready == 1'b1, "R9 ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R9 taken", out_valid, 0);
    pull(eb, "R9 new");
  endtask

  task automatic t_flush();  // R10
    for (int i = 0; i < 4; i++) run_one(12'hFFF, 5'd6, "R10 load");
    do_reset();
    for (int i = 0; i < 6; i++) run_one(ZERO_CODE, 5'd0, "R10 flushed");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
      end
    end
  end

  initial begin
    m_clear();
    t_reset_state();
    t_zero_level();
    t_clamp();
    t_impulse();
    t_tone();
    t_scale();
    t_full_swing();
    t_backpressure();
    t_overlap();
    t_flush();
    finish_run();
  end
endmodule